// File: doc/BRIEF.md
# Multiplexer-Steered Ripple ALU

This block is a purely combinational arithmetic and logic unit of parameterised width (16 bits by default). It is built as a chain of identical bit slices.

In every slice, a four-way operand selector feeds the second input of a single full adder. The selector offers constant zero, constant one, the B bit, or the inverted B bit. This lets one ripple adder serve four arithmetic operations: addition, subtraction, increment and decrement. The same adder also produces AND, OR, XOR and XNOR terms. A per-slice result selector hands either the sum or one of those terms to the output. The carry out of the most significant slice becomes the carry output.

A 3-bit operation code drives the unit. Its top bit chooses between the arithmetic class and the logic class, and its two low bits choose the operation within that class. There is no clock and no state: the result follows the inputs after the ripple delay.

Top module: `mux_ripple_alu`

## Requirements
- R1: With op = 3'b000 (add), {cout, res} equals a + b + cin as an unsigned WIDTH+1-bit sum. A carry entering at bit 0 propagates through all bits, so a = 0xFFFF, b = 0, cin = 1 gives res = 0 and cout = 1.
- R2: With op = 3'b001 (subtract), res equals a - b modulo 2^WIDTH. cout is 1 exactly when a >= b unsigned. cin has no effect.
- R3: With op = 3'b010 (increment), res equals a + 1 modulo 2^WIDTH. cout is 1 only for a = all ones. b and cin have no effect.
- R4: With op = 3'b011 (decrement), res equals a - 1 modulo 2^WIDTH. cout is 0 only for a = 0. b and cin have no effect.
- R5: With op = 3'b100, res equals a AND b. With op = 3'b101, res equals a OR b.
- R6: With op = 3'b110, res equals a XOR b. With op = 3'b111, res equals a XNOR b.
- R7: Whenever op[2] = 1 (logic class), cout is 0 and cin has no effect on res.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, steered through the operand selector |
| op_i | input | 3 | Operation code; bit 2 chooses logic (1) or arithmetic (0) |
| cin_i | input | 1 | Carry input, used by add only |
| res_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the top slice; 0 in logic class |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume the operands, operation code and carry are two-valued and settle together, with no mid-change sampling. The bench changes all inputs in one step just after a clock edge and compares half a period later, so every comparison sees fully settled values. Stimulus covers every operation code, both carry values, the operands 0, 0xFFFF, 0x8000, 0x7FFF and 1 crossed with each other, and then random operands.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and operand-selector codes for the ALU.
// Assumes op[2] marks the logic class; low two bits pick within the class.
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_INC  = 3'b010,
        OP_DEC  = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_XNOR = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        OPND_ZERO = 2'b00,
        OPND_ONE  = 2'b01,
        OPND_B    = 2'b10,
        OPND_BN   = 2'b11
    } opnd_sel_e;

    typedef enum logic [1:0] {
        LOG_AND  = 2'b00,
        LOG_OR   = 2'b01,
        LOG_XOR  = 2'b10,
        LOG_XNOR = 2'b11
    } log_sel_e;

endpackage

// File: rtl/alu_operand_mux.sv
// Module: per-slice 4:1 selector producing the adder's second input bit.
// Assumes sel_i is one of the opnd_sel_e codes; purely combinational.
module alu_operand_mux
    import alu_pkg::*;
(
    input  logic      b_i,
    input  opnd_sel_e sel_i,
    output logic      opnd_o
);

    // Pick constant zero, constant one, B or inverted B.
    always_comb begin
        unique case (sel_i)
            OPND_ZERO: opnd_o = 1'b0;
            OPND_ONE:  opnd_o = 1'b1;
            OPND_B:    opnd_o = b_i;
            default:   opnd_o = ~b_i;
        endcase
    end

endmodule

// File: rtl/alu_full_adder.sv
// Module: one-bit full adder that also exposes its gate terms.
// The AND, OR, XOR and XNOR outputs are those of the two adder inputs.
// Assumes single-bit inputs; purely combinational.
module alu_full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic sum_o,
    output logic carry_o,
    output logic and_o,
    output logic or_o,
    output logic xor_o,
    output logic xnor_o
);

    // Gate terms shared by the sum, the carry and the logic results.
    always_comb begin
        and_o   = x_i & y_i;
        or_o    = x_i | y_i;
        xor_o   = x_i ^ y_i;
        xnor_o  = ~xor_o;
        sum_o   = xor_o ^ c_i;
        carry_o = and_o | (xor_o & c_i);
    end

endmodule

// File: rtl/alu_result_mux.sv
// Module: per-slice output selector choosing the sum or one gate term.
// Assumes logic_i set means the logic class; purely combinational.
module alu_result_mux
    import alu_pkg::*;
(
    input  logic     logic_i,
    input  log_sel_e lsel_i,
    input  logic     sum_i,
    input  logic     and_i,
    input  logic     or_i,
    input  logic     xor_i,
    input  logic     xnor_i,
    output logic     bit_o
);

    // Route the arithmetic sum, or the requested logic term.
    always_comb begin
        if (!logic_i) begin
            bit_o = sum_i;
        end else begin
            unique case (lsel_i)
                LOG_AND:  bit_o = and_i;
                LOG_OR:   bit_o = or_i;
                LOG_XOR:  bit_o = xor_i;
                default:  bit_o = xnor_i;
            endcase
        end
    end

endmodule

// File: rtl/mux_ripple_alu.sv
// Module: top of the ripple ALU; WIDTH identical slices in a carry chain.
// Decodes the operation into an operand-selector code, the bit-0 carry and
// the result-selector code. Assumes two-valued inputs; no clock or state.
module mux_ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);

    localparam logic [WIDTH-1:0] ONE_W = {{(WIDTH-1){1'b0}}, 1'b1};

    alu_op_e          op;
    opnd_sel_e        opnd_sel;
    log_sel_e         log_sel;
    logic             logic_mode;
    logic [WIDTH:0]   carry;

    // Decode the operation code into selector controls and the bit-0 carry.
    always_comb begin
        op         = alu_op_e'(op_i);
        logic_mode = op_i[2];
        log_sel    = log_sel_e'(op_i[1:0]);
        unique case (op)
            OP_ADD:  begin opnd_sel = OPND_B;    carry[0] = cin_i; end
            OP_SUB:  begin opnd_sel = OPND_BN;   carry[0] = 1'b1;  end
            OP_INC:  begin opnd_sel = OPND_ZERO; carry[0] = 1'b1;  end
            OP_DEC:  begin opnd_sel = OPND_ONE;  carry[0] = 1'b0;  end
            default: begin opnd_sel = OPND_B;    carry[0] = 1'b0;  end
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic opnd, sum, t_and, t_or, t_xor, t_xnor;

        alu_operand_mux i_opnd (
            .b_i    (b_i[i]),
            .sel_i  (opnd_sel),
            .opnd_o (opnd)
        );

        alu_full_adder i_fa (
            .x_i     (a_i[i]),
            .y_i     (opnd),
            .c_i     (carry[i]),
            .sum_o   (sum),
            .carry_o (carry[i+1]),
            .and_o   (t_and),
            .or_o    (t_or),
            .xor_o   (t_xor),
            .xnor_o  (t_xnor)
        );

        alu_result_mux i_res (
            .logic_i (logic_mode),
            .lsel_i  (log_sel),
            .sum_i   (sum),
            .and_i   (t_and),
            .or_i    (t_or),
            .xor_i   (t_xor),
            .xnor_i  (t_xnor),
            .bit_o   (res_o[i])
        );
    end

    // Expose the top carry in arithmetic class, force zero in logic class.
    always_comb begin
        cout_o = logic_mode ? 1'b0 : carry[WIDTH];
    end

    // Port-level relations between the operation and the settled outputs.
    always_comb begin
        if (op_i == 3'b000) begin
            a_r1_add_sum: assert ({cout_o, res_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
        end
        if (op_i == 3'b001) begin
            a_r2_sub_inverse: assert (WIDTH'(res_o + b_i) == a_i);
            a_r2_sub_borrow:  assert (cout_o == (a_i >= b_i));
        end
        if (op_i == 3'b010) begin
            a_r3_inc_step: assert (WIDTH'(res_o - a_i) == ONE_W);
        end
        if (op_i == 3'b011) begin
            a_r4_dec_step: assert (WIDTH'(res_o + ONE_W) == a_i);
        end
        if (op_i == 3'b100) begin
            a_r5_and_bits: assert ((res_o | a_i) == a_i && (res_o | b_i) == b_i);
        end
        if (op_i == 3'b110) begin
            a_r6_xor_undo: assert ((res_o ^ b_i) == a_i);
        end
        if (op_i[2]) begin
            a_r7_logic_no_carry: assert (cout_o == 1'b0);
        end
    end

endmodule

// File: tb/test_mux_ripple_alu.sv
// Bench: drives every operation with corner and random operands just after
// each rising edge and compares against an integer reference at the
// falling edge.
module test_mux_ripple_alu;

    localparam int WIDTH = 16;
    localparam int MASK  = (1 << WIDTH) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] a = '0, b = '0;
    logic [2:0]       op = 3'b000;
    logic             cin = 1'b0;
    logic [WIDTH-1:0] res;
    logic             cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mux_ripple_alu #(.WIDTH(WIDTH)) i_mux_ripple_alu (
        .a_i    (a),
        .b_i    (b),
        .op_i   (op),
        .cin_i  (cin),
        .res_o  (res),
        .cout_o (cout)
    );

    // Requirement tag for each operation code.
    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100, 3'b101: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Behavioural reference: 17-bit integer result {carry, value}.
    function automatic int model(input int x, input int y, input logic [2:0] o, input int c);
        case (o)
            3'b000: return x + y + c;
            3'b001: return x + ((~y) & MASK) + 1;
            3'b010: return x + 1;
            3'b011: return x + MASK;
            3'b100: return x & y;
            3'b101: return x | y;
            3'b110: return x ^ y;
            default: return (~(x ^ y)) & MASK;
        endcase
    endfunction

    // Compare one settled output pair with the reference.
    task automatic compare(input string tag);
        int exp_v, exp_r, exp_c;
        exp_v = model(int'(a), int'(b), op, int'(cin));
        exp_r = exp_v & MASK;
        exp_c = op[2] ? 0 : ((exp_v >> WIDTH) & 1);
        checks++;
        if (int'(res) != exp_r || int'(cout) != exp_c) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h cin=%b: res=%h cout=%0d expected res=%h cout=%0d",
                     tag, op, a, b, cin, res, cout, exp_r[WIDTH-1:0], exp_c);
        end
    endtask

    // Apply one vector after a rising edge, check at the falling edge.
    task automatic apply(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                         input logic [2:0] o, input logic c);
        @(posedge clk);
        #1;
        a = x; b = y; op = o; cin = c;
        @(negedge clk);
        compare(tag_of(o));
        if (o[2]) compare("R7");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic [WIDTH-1:0] corners [5];
        corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
        corners[3] = 16'h7FFF; corners[4] = 16'h0001;

        // Reset state: zero inputs give a zero add result and no carry (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // Full carry ripple (R1).
        apply(16'hFFFF, 16'h0000, 3'b000, 1'b1);
        // Subtract equal operands gives zero with carry (R2).
        apply(16'h1234, 16'h1234, 3'b001, 1'b0);
        // Increment wrap (R3) and decrement of zero (R4).
        apply(16'hFFFF, 16'h5555, 3'b010, 1'b0);
        apply(16'h0000, 16'hAAAA, 3'b011, 1'b1);

        // Corners crossed with every operation and both carry values.
        for (int oi = 0; oi < 8; oi++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int c = 0; c < 2; c++)
                        apply(corners[i], corners[j], 3'(oi), 1'(c));

        // Random operands for every operation.
        for (int k = 0; k < 3000; k++)
            apply(WIDTH'($urandom), WIDTH'($urandom), 3'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule